// File: doc/BRIEF.md
# Hashed Way-Prediction Array

This block guesses which way of an eight-way, virtually indexed L1 data cache holds a load's data. It does this before any address translation or full tag compare. Each row of the array holds, for every way, a compact 11-bit hash of the effective address, one valid bit for each of the two hardware threads, and a parity bit. A lookup uses six address bits to pick the row. The block folds higher address bits into an 11-bit key and compares it against all eight ways at once. For a clean single match it returns a one-hot way select one cycle later.

Lines are installed when the cache validates them. An install is shared by default, which marks the entry valid for both threads. A private install marks it valid only for the installing thread, so each thread can keep its own copy of the same hash in a different way. An invalidate port clears either thread's valid bit or both. A sticky way-delete control retires a faulty way: after it, that way never predicts and never accepts installs again. Parity is checked on every matching entry. Ambiguous results and parity faults are reported as misses, never as a way select.

The lookup result is held in a registered state, one of four. RS_IDLE means no lookup was presented on the previous cycle. RS_HIT means exactly one clean way matched. RS_MISS means no way matched, or several did. RS_PERR means a matching way failed its parity check. Each cycle the state moves to the value set by the current lookup. The move goes to RS_IDLE when lk_valid is low. Otherwise it goes to RS_PERR if any matching way has bad parity, to RS_HIT if exactly one way matches, and to RS_MISS in all other cases. Reset forces RS_IDLE.

Top module: `wp_predict`

## Requirements
- R1: The row is selected by address bits [12:7] (port bit n is little-endian bit n of the 64-bit effective address). This gives 64 rows of eight ways.
- R2: The key is {ea[31:24] ^ ea[23:16], ea[15:13]}, 11 bits with the XOR result in the upper eight bits. Two addresses with equal XOR, equal ea[15:13] and equal row hit the same entry.
- R3: A shared install (fill_priv = 0) makes the entry valid for thread 0 and for thread 1.
- R4: When exactly one way of the row has a stored key equal to the lookup key and has the requesting thread's valid bit set, pred_hit is 1 and pred_way has only bit w set, where w is the matching way.
- R5: A private install (fill_priv = 1) makes the entry valid only for fill_tid. The same key installed privately in two ways by different threads predicts a different way for each thread.
- R6: When no way matches, or two or more ways match, pred_hit is 0, pred_way is 0 and pred_perr is 0.
- R7: Stored parity is the XOR of the 11 key bits, inverted when fill_par_inj is 1. If any matching way has wrong parity, pred_perr is 1 for that result and pred_hit and pred_way are 0. A parity fault in a way that does not match has no effect.
- R8: pred_valid is 1 exactly in the cycle after a cycle with lk_valid = 1, and it carries that lookup's result. An install or invalidate is seen by lookups from the next cycle on, not by a lookup in the same cycle.
- R9: An invalidate clears the valid bit of thread t for the given row and way when inv_mask[t] is 1. Other bits are left as they were. If an invalidate hits the entry being installed in the same cycle, it is applied after the install.
- R10: After del_valid names way w, way w never produces a hit in any row, and installs to way w are dropped, until reset.
- R11: After reset, every entry is invalid, no way is deleted, and pred_valid, pred_hit, pred_way and pred_perr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_ea | input | 25 | Lookup effective address bits [31:7] |
| lk_tid | input | 1 | Requesting thread |
| fill_valid | input | 1 | Install request |
| fill_ea | input | 25 | Install effective address bits [31:7] |
| fill_way | input | 3 | Way to install into |
| fill_tid | input | 1 | Installing thread (used for private installs) |
| fill_priv | input | 1 | 1 = private to fill_tid, 0 = shared by both threads |
| fill_par_inj | input | 1 | Inverts the stored parity bit of this install |
| inv_valid | input | 1 | Invalidate request |
| inv_row | input | 6 | Row to invalidate |
| inv_way | input | 3 | Way to invalidate |
| inv_mask | input | 2 | Bit t clears thread t's valid bit |
| del_valid | input | 1 | Way-delete request |
| del_way | input | 3 | Way to retire permanently |
| pred_valid | output | 1 | A lookup result is present |
| pred_hit | output | 1 | Single clean way match |
| pred_way | output | 8 | One-hot predicted way, bit w = way w |
| pred_perr | output | 1 | Parity fault in a matching way |

## Verification
The assertions check on every cycle that a result appears exactly one cycle after each lookup and never otherwise. They also check that a hit carries exactly one way bit, that a miss or parity fault carries none, and that a deleted way is never predicted. The bench's scenarios alone can show which way is chosen for a given key and thread. They also cover shared versus private installs, multi-way ambiguity, parity faults, and the way invalidates and installs interact with a lookup in the same cycle. The bench fills all 512 entries with distinct keys and looks each up from both threads. For every lookup it builds the address with varying upper-field values that fold to the same key.

// File: rtl/wp_pkg.sv
package wp_pkg;
    // Address field positions, little-endian numbering of the 64-bit address
    localparam int EA_LO        = 7;
    localparam int EA_HI        = 31;
    localparam int IDX_LSB      = 7;
    localparam int IDX_W        = 6;
    localparam int FOLD_A_LSB   = 24;
    localparam int FOLD_B_LSB   = 16;
    localparam int FOLD_W       = 8;
    localparam int TAIL_LSB     = 13;
    localparam int TAIL_W       = 3;
    localparam int HASH_W       = FOLD_W + TAIL_W;
    localparam int ROWS         = 1 << IDX_W;

    typedef logic [EA_HI:EA_LO] ea_t;
    typedef logic [HASH_W-1:0]  hash_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef struct packed {
        hash_t      tag;
        logic [1:0] vld;
        logic       par;
    } entry_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_PERR
    } res_e;

    function automatic idx_t ea_index(input ea_t ea);
        return ea[IDX_LSB +: IDX_W];
    endfunction

    function automatic hash_t ea_hash(input ea_t ea);
        return {ea[FOLD_A_LSB +: FOLD_W] ^ ea[FOLD_B_LSB +: FOLD_W],
                ea[TAIL_LSB +: TAIL_W]};
    endfunction
endpackage

// File: rtl/wp_way_match.sv
module wp_way_match
    import wp_pkg::*;
(
    input  entry_t ent,
    input  hash_t  key,
    input  logic   tid,
    input  logic   disabled,
    output logic   hit,
    output logic   perr
);
    // A way matches on equal key with the requester's valid bit set
    always_comb begin
        hit  = !disabled && ent.vld[tid] && (ent.tag == key);
        perr = hit && ((^ent.tag) != ent.par);
    end
endmodule

// File: rtl/wp_store.sv
module wp_store
    import wp_pkg::*;
#(
    parameter  int NWAYS = 8,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  idx_t                   rd_idx,
    output entry_t [NWAYS-1:0]     rd_row,
    output logic   [NWAYS-1:0]     dis_mask,
    input  logic                   wr_en,
    input  idx_t                   wr_idx,
    input  logic   [WAY_W-1:0]     wr_way,
    input  hash_t                  wr_hash,
    input  logic                   wr_tid,
    input  logic                   wr_priv,
    input  logic                   wr_inj,
    input  logic                   inv_en,
    input  idx_t                   inv_idx,
    input  logic   [WAY_W-1:0]     inv_way,
    input  logic   [1:0]           inv_mask,
    input  logic                   del_en,
    input  logic   [WAY_W-1:0]     del_way
);
    entry_t mem [ROWS][NWAYS];

    entry_t fill_ent, inv_ent;
    logic   fill_go, inv_go, same_slot;

    always_comb begin
        for (int w = 0; w < NWAYS; w++) begin
            rd_row[w] = mem[rd_idx][w];
        end
    end

    always_comb begin
        fill_go      = wr_en && !dis_mask[wr_way];
        same_slot    = inv_en && (inv_idx == wr_idx) && (inv_way == wr_way);
        fill_ent.tag = wr_hash;
        fill_ent.vld = wr_priv ? (2'b01 << wr_tid) : 2'b11;
        fill_ent.par = (^wr_hash) ^ wr_inj;
        if (same_slot) begin
            fill_ent.vld = fill_ent.vld & ~inv_mask;
        end
        inv_go       = inv_en && !(fill_go && same_slot);
        inv_ent      = mem[inv_idx][inv_way];
        inv_ent.vld  = inv_ent.vld & ~inv_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    mem[r][w] <= '0;
                end
            end
            dis_mask <= '0;
        end else begin
            if (fill_go) begin
                mem[wr_idx][wr_way] <= fill_ent;
            end
            if (inv_go) begin
                mem[inv_idx][inv_way] <= inv_ent;
            end
            if (del_en) begin
                dis_mask[del_way] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wp_predict.sv
module wp_predict
    import wp_pkg::*;
#(
    parameter  int NWAYS = 8,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [EA_HI:EA_LO] lk_ea,
    input  logic               lk_tid,
    input  logic               fill_valid,
    input  logic [EA_HI:EA_LO] fill_ea,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic               fill_tid,
    input  logic               fill_priv,
    input  logic               fill_par_inj,
    input  logic               inv_valid,
    input  logic [IDX_W-1:0]   inv_row,
    input  logic [WAY_W-1:0]   inv_way,
    input  logic [1:0]         inv_mask,
    input  logic               del_valid,
    input  logic [WAY_W-1:0]   del_way,
    output logic               pred_valid,
    output logic               pred_hit,
    output logic [NWAYS-1:0]   pred_way,
    output logic               pred_perr
);
    entry_t [NWAYS-1:0] rd_row;
    logic   [NWAYS-1:0] dis_mask, match, perr_way, way_q;
    hash_t              lk_key;
    res_e               state_q, state_d;

    assign lk_key = ea_hash(lk_ea);

    wp_store #(.NWAYS(NWAYS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ea_index(lk_ea)),
        .rd_row   (rd_row),
        .dis_mask (dis_mask),
        .wr_en    (fill_valid),
        .wr_idx   (ea_index(fill_ea)),
        .wr_way   (fill_way),
        .wr_hash  (ea_hash(fill_ea)),
        .wr_tid   (fill_tid),
        .wr_priv  (fill_priv),
        .wr_inj   (fill_par_inj),
        .inv_en   (inv_valid),
        .inv_idx  (inv_row),
        .inv_way  (inv_way),
        .inv_mask (inv_mask),
        .del_en   (del_valid),
        .del_way  (del_way)
    );

    for (genvar gw = 0; gw < NWAYS; gw++) begin : g_way
        wp_way_match u_match (
            .ent      (rd_row[gw]),
            .key      (lk_key),
            .tid      (lk_tid),
            .disabled (dis_mask[gw]),
            .hit      (match[gw]),
            .perr     (perr_way[gw])
        );
    end

    // Transition selection
    always_comb begin
        if (!lk_valid) begin
            state_d = RS_IDLE;
        end else if (|perr_way) begin
            state_d = RS_PERR;
        end else if ($onehot(match)) begin
            state_d = RS_HIT;
        end else begin
            state_d = RS_MISS;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            way_q   <= match;
        end
    end

    // Outputs
    always_comb begin
        pred_valid = 1'b1;
        pred_hit   = 1'b0;
        pred_way   = '0;
        pred_perr  = 1'b0;
        unique case (state_q)
            RS_IDLE: pred_valid = 1'b0;
            RS_HIT: begin
                pred_hit = 1'b1;
                pred_way = way_q;
            end
            RS_MISS: ;
            RS_PERR: pred_perr = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_predict_chk.sv
module wp_predict_chk #(
    parameter  int NWAYS = 8,
    localparam int WAY_W = $clog2(NWAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             del_valid,
    input logic [WAY_W-1:0] del_way,
    input logic             pred_valid,
    input logic             pred_hit,
    input logic [NWAYS-1:0] pred_way,
    input logic             pred_perr
);
    logic [NWAYS-1:0] del_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            del_q <= '0;
        end else if (del_valid) begin
            del_q[del_way] <= 1'b1;
        end
    end

    a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pred_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !pred_valid);

    a_r4_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> ($countones(pred_way) == 1) && pred_valid);

    a_r6_miss_no_way: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (pred_way == '0));

    a_r7_perr_excludes_hit: assert property (@(posedge clk) disable iff (!rst_n)
        pred_perr |-> pred_valid && !pred_hit);

    a_r10_deleted_never: assert property (@(posedge clk) disable iff (!rst_n)
        pred_hit |-> ((pred_way & $past(del_q)) == '0));
endmodule

bind wp_predict wp_predict_chk #(.NWAYS(NWAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .del_valid  (del_valid),
    .del_way    (del_way),
    .pred_valid (pred_valid),
    .pred_hit   (pred_hit),
    .pred_way   (pred_way),
    .pred_perr  (pred_perr)
);

// File: tb/wp_predict_tb.sv
module wp_predict_tb;
    import wp_pkg::*;

    localparam int NW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          lk_valid = 0, lk_tid = 0;
    logic [31:7]   lk_ea = '0, fill_ea = '0;
    logic          fill_valid = 0, fill_tid = 0, fill_priv = 0, fill_par_inj = 0;
    logic [2:0]    fill_way = '0, inv_way = '0, del_way = '0;
    logic          inv_valid = 0, del_valid = 0;
    logic [5:0]    inv_row = '0;
    logic [1:0]    inv_mask = '0;
    logic          pred_valid, pred_hit, pred_perr;
    logic [NW-1:0] pred_way;

    wp_predict u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_tid(lk_tid),
        .fill_valid(fill_valid), .fill_ea(fill_ea), .fill_way(fill_way),
        .fill_tid(fill_tid), .fill_priv(fill_priv), .fill_par_inj(fill_par_inj),
        .inv_valid(inv_valid), .inv_row(inv_row), .inv_way(inv_way), .inv_mask(inv_mask),
        .del_valid(del_valid), .del_way(del_way),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_way(pred_way), .pred_perr(pred_perr)
    );

    int vecs = 0;
    int errs = 0;

    // Reference state built from the requirements
    logic [10:0] m_tag [64][NW];
    logic [1:0]  m_vld [64][NW];
    logic        m_bad [64][NW];
    logic [NW-1:0] m_del;

    function automatic logic [31:7] mk_ea(input int row, input logic [10:0] h, input logic [7:0] salt);
        logic [63:0] a;
        a = {32'h1357_9BDF ^ {4{salt}}, 32'h0};
        a[31:24] = h[10:3] ^ salt;
        a[23:16] = salt;
        a[15:13] = h[2:0];
        a[12:7]  = row[5:0];
        a[6:0]   = salt[6:0];
        return a[31:7];
    endfunction

    function automatic logic [10:0] key_of(input int row, input int way);
        return 11'((row * 8 + way) * 3 + 5);
    endfunction

    task automatic check(input string tag, input logic ev, input logic eh,
                         input logic [NW-1:0] ew, input logic ep);
        vecs++;
        if (pred_valid !== ev || pred_hit !== eh || pred_way !== ew || pred_perr !== ep) begin
            errs++;
            $display("FAIL %s: got v=%0b h=%0b w=%b p=%0b exp v=%0b h=%0b w=%b p=%0b",
                     tag, pred_valid, pred_hit, pred_way, pred_perr, ev, eh, ew, ep);
        end
    endtask

    task automatic expect_of(input int row, input logic [10:0] h, input logic tid,
                             output logic eh, output logic [NW-1:0] ew, output logic ep);
        logic [NW-1:0] mv;
        ep = 1'b0;
        mv = '0;
        for (int w = 0; w < NW; w++) begin
            mv[w] = !m_del[w] && m_vld[row][w][tid] && (m_tag[row][w] == h);
            if (mv[w] && m_bad[row][w]) ep = 1'b1;
        end
        eh = !ep && ($countones(mv) == 1);
        ew = eh ? mv : '0;
    endtask

    task automatic clear_reqs();
        lk_valid = 0; fill_valid = 0; inv_valid = 0; del_valid = 0; fill_par_inj = 0;
    endtask

    task automatic lookup(input string tag, input int row, input logic [10:0] h,
                          input logic tid, input logic [7:0] salt);
        logic eh, ep;
        logic [NW-1:0] ew;
        expect_of(row, h, tid, eh, ew, ep);
        @(negedge clk);
        lk_valid = 1; lk_ea = mk_ea(row, h, salt); lk_tid = tid;
        @(posedge clk); #1 clear_reqs();
        @(negedge clk);
        check(tag, 1'b1, eh, ew, ep);
    endtask

    task automatic model_fill(input int row, input int way, input logic [10:0] h,
                              input logic tid, input logic priv, input logic inj);
        if (!m_del[way]) begin
            m_tag[row][way] = h;
            m_vld[row][way] = priv ? (tid ? 2'b10 : 2'b01) : 2'b11;
            m_bad[row][way] = inj;
        end
    endtask

    task automatic fill(input int row, input int way, input logic [10:0] h,
                        input logic tid, input logic priv, input logic inj);
        @(negedge clk);
        fill_valid = 1; fill_ea = mk_ea(row, h, 8'(row * 5 + way)); fill_way = 3'(way);
        fill_tid = tid; fill_priv = priv; fill_par_inj = inj;
        @(posedge clk); #1 clear_reqs();
        model_fill(row, way, h, tid, priv, inj);
    endtask

    task automatic inval(input int row, input int way, input logic [1:0] mask);
        @(negedge clk);
        inv_valid = 1; inv_row = 6'(row); inv_way = 3'(way); inv_mask = mask;
        @(posedge clk); #1 clear_reqs();
        m_vld[row][way] = m_vld[row][way] & ~mask;
    endtask

    task automatic del(input int way);
        @(negedge clk);
        del_valid = 1; del_way = 3'(way);
        @(posedge clk); #1 clear_reqs();
        m_del[way] = 1'b1;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        summary();
        $finish;
    end

    initial begin
        logic eh, ep;
        logic [NW-1:0] ew;
        m_del = '0;
        for (int r = 0; r < 64; r++)
            for (int w = 0; w < NW; w++) begin
                m_tag[r][w] = '0; m_vld[r][w] = '0; m_bad[r][w] = 0;
            end

        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset outputs", 1'b0, 1'b0, '0, 1'b0);
        rst_n = 1'b1;
        for (int r = 0; r < 4; r++) lookup("R11 empty after reset", r * 17, 11'(r), 1'b0, 8'h3C);

        // R1 R2 R3 R4: fill every entry shared, look up from both threads
        for (int r = 0; r < 64; r++)
            for (int w = 0; w < NW; w++)
                fill(r, w, key_of(r, w), 1'b0, 1'b0, 1'b0);
        for (int r = 0; r < 64; r++)
            for (int w = 0; w < NW; w++)
                for (int t = 0; t < 2; t++)
                    lookup("R1 R2 R3 R4 sweep", r, key_of(r, w), 1'(t), 8'(r * 13 + w * 7 + t));

        // R8: no lookup, no result
        @(negedge clk);
        @(negedge clk);
        check("R8 idle cycle", 1'b0, 1'b0, '0, 1'b0);

        // R6: absent key and one-bit-off key
        lookup("R6 absent key", 3, 11'h7FF, 1'b0, 8'h11);
        lookup("R6 one bit off", 4, key_of(4, 2) ^ 11'h001, 1'b1, 8'h22);

        // R8: install and lookup in the same cycle see the old contents
        expect_of(10, 11'h7F0, 1'b0, eh, ew, ep);
        @(negedge clk);
        fill_valid = 1; fill_ea = mk_ea(10, 11'h7F0, 8'h44); fill_way = 3'd0;
        fill_tid = 0; fill_priv = 0;
        lk_valid = 1; lk_ea = mk_ea(10, 11'h7F0, 8'h55); lk_tid = 0;
        @(posedge clk); #1 clear_reqs();
        model_fill(10, 0, 11'h7F0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 same-cycle install unseen", 1'b1, eh, ew, ep);
        lookup("R8 install seen next cycle", 10, 11'h7F0, 1'b0, 8'h66);

        // R5: private installs of one key for each thread
        fill(20, 1, 11'h700, 1'b0, 1'b1, 1'b0);
        fill(20, 2, 11'h700, 1'b1, 1'b1, 1'b0);
        lookup("R5 thread0 own way", 20, 11'h700, 1'b0, 8'h01);
        lookup("R5 thread1 own way", 20, 11'h700, 1'b1, 8'h02);

        // R6: two ways hold the same key
        fill(21, 3, 11'h701, 1'b0, 1'b0, 1'b0);
        fill(21, 4, 11'h701, 1'b0, 1'b0, 1'b0);
        lookup("R6 multi match", 21, 11'h701, 1'b0, 8'h03);

        // R7: parity fault in matching and in non-matching ways
        fill(22, 5, 11'h702, 1'b0, 1'b0, 1'b1);
        lookup("R7 parity fault reported", 22, 11'h702, 1'b1, 8'h04);
        fill(22, 6, 11'h703, 1'b1, 1'b1, 1'b1);
        lookup("R7 fault in non-match ignored", 22, 11'h703, 1'b0, 8'h05);
        lookup("R7 other way still hits", 22, key_of(22, 0), 1'b0, 8'h06);

        // R9: invalidates per thread
        inval(30, 7, 2'b01);
        lookup("R9 thread0 cleared", 30, key_of(30, 7), 1'b0, 8'h07);
        lookup("R9 thread1 kept", 30, key_of(30, 7), 1'b1, 8'h08);
        inval(30, 7, 2'b10);
        lookup("R9 both cleared", 30, key_of(30, 7), 1'b1, 8'h09);
        inval(31, 0, 2'b11);
        lookup("R9 mask 11 thread0", 31, key_of(31, 0), 1'b0, 8'h0A);
        lookup("R9 mask 11 thread1", 31, key_of(31, 0), 1'b1, 8'h0B);

        // R9: invalidate and install on one entry in one cycle
        @(negedge clk);
        fill_valid = 1; fill_ea = mk_ea(32, 11'h705, 8'h77); fill_way = 3'd3;
        fill_tid = 0; fill_priv = 0;
        inv_valid = 1; inv_row = 6'd32; inv_way = 3'd3; inv_mask = 2'b01;
        @(posedge clk); #1 clear_reqs();
        model_fill(32, 3, 11'h705, 1'b0, 1'b0, 1'b0);
        m_vld[32][3] = m_vld[32][3] & ~2'b01;
        lookup("R9 invalidate after install t0", 32, 11'h705, 1'b0, 8'h0C);
        lookup("R9 invalidate after install t1", 32, 11'h705, 1'b1, 8'h0D);

        // R10: way delete
        lookup("R10 before delete", 40, key_of(40, 5), 1'b0, 8'h0E);
        del(5);
        lookup("R10 deleted way silent", 40, key_of(40, 5), 1'b0, 8'h0F);
        fill(41, 5, 11'h704, 1'b0, 1'b0, 1'b0);
        lookup("R10 install dropped", 41, 11'h704, 1'b0, 8'h10);
        lookup("R10 other way unaffected", 40, key_of(40, 4), 1'b1, 8'h12);

        summary();
        $finish;
    end
endmodule